// File: doc/BRIEF.md
# PPS Phase Capture Counter

This block measures where an external one-pulse-per-second reference lands relative to a local oscillator. A free-running counter, clocked by the local 10 MHz oscillator, divides it down to exactly one second. Its top bit is brought out as a locally generated PPS pulse. Each rising edge of the external reference takes a snapshot of the counter. The snapshot is the phase offset between the local second and the reference second, in oscillator cycles.

A host reads the snapshot through a three-wire serial port made of an active-low select, a serial clock and a data line. The reference and both host inputs are asynchronous. Each passes through a two-flop synchroniser before any edge is detected, and every register in the block runs on the oscillator clock. The snapshot goes first into a capture register. At the start of each read it is copied into a separate shift register, so a reference edge that arrives during a read cannot disturb the bits already being shifted. A sticky status bit goes out ahead of the value and tells the host whether the snapshot is new since its last read.

Top module: `pps_phase_capture`

## Requirements
- R1: The counter resets to 0, advances by one on every clock and returns to 0 after reaching MODULUS-1 (9,999,999 by default).
- R2: `pps_local` is high exactly while the count is at least 2^(CNT_W-1). With the default parameters it is high from 8,388,608 to 9,999,999, which is 1,611,392 cycles.
- R3: Suppose `pps_ref` rises between two clock edges while the count is N. The captured value is then (N+2) mod MODULUS, taken at the third clock edge after the rise.
- R4: Only a rising edge of `pps_ref` captures. While `pps_ref` stays high, neither the value nor the status bit changes again.
- R5: A read frame is CNT_W+1 bits long. Its first bit is the status bit, followed by the captured value MSB first. `rd_data` shows the current bit while `rd_sel_n` is low, and it moves to the next bit after each rising edge of `rd_clk`.
- R6: The frame is fixed when `rd_sel_n` falls. A capture that occurs during a read leaves that frame unchanged, and the new value appears in the next read.
- R7: A capture sets the status bit, and the start of a read clears it. A second read with no capture in between returns status 0 and the same value.
- R8: `rd_data` is 0 whenever `rd_sel_n` is high.
- R9: A synchronous active-high reset clears the counter, the capture, the status bit and the shift register, so the next read returns an all-zero frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock; all registers use it |
| rst | input | 1 | Synchronous active-high reset |
| pps_ref | input | 1 | Asynchronous external second reference |
| pps_local | output | 1 | Locally generated second pulse (counter MSB) |
| rd_sel_n | input | 1 | Asynchronous active-low read select from host |
| rd_clk | input | 1 | Asynchronous serial clock from host |
| rd_data | output | 1 | Serial read data, 0 when not selected |

## Verification
The bench builds the block with CNT_W=6 and MODULUS=40, so the counter wraps every 40 cycles and `pps_local` is high for counts 32 to 39. With a period this short, the bench can capture the reference at every one of the 40 counter phases, wrap point included, and read each result back. It can also check `pps_local` over two full periods. The same small setup leaves room for the interleaving cases in a few hundred cycles: a reference held high, two reads of the same snapshot, a capture during a read, and reset.

// File: rtl/pps_phase_capture.sv
module pps_phase_capture #(
  parameter int CNT_W   = 24,
  parameter int MODULUS = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_ref,
  output logic pps_local,
  input  logic rd_sel_n,
  input  logic rd_clk,
  output logic rd_data
);
  localparam int FRAME = CNT_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

  logic [CNT_W-1:0] cnt, cap;
  logic [FRAME-1:0] shreg;
  logic             fresh;
  logic [2:0]       pps_s, sel_s, sck_s;

  logic pps_rise, rd_start, rd_active, sck_rise;
  assign pps_rise  = pps_s[1] & ~pps_s[2];
  assign rd_start  = sel_s[2] & ~sel_s[1];
  assign rd_active = ~sel_s[1] & ~sel_s[2];
  assign sck_rise  = sck_s[1] & ~sck_s[2];

  assign pps_local = cnt[CNT_W-1];
  assign rd_data   = rd_active & shreg[FRAME-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pps_s <= '0;
      sel_s <= '1;
      sck_s <= '0;
    end else begin
      pps_s <= {pps_s[1:0], pps_ref};
      sel_s <= {sel_s[1:0], rd_sel_n};
      sck_s <= {sck_s[1:0], rd_clk};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           cap <= '0;
    else if (pps_rise) cap <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)           fresh <= 1'b0;
    else if (pps_rise) fresh <= 1'b1;
    else if (rd_start) fresh <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                        shreg <= '0;
    else if (rd_start)              shreg <= {fresh, cap};
    else if (rd_active && sck_rise) shreg <= {shreg[FRAME-2:0], 1'b0};
  end
endmodule

module pps_phase_capture_chk #(
  parameter int CNT_W   = 24,
  parameter int MODULUS = 10_000_000
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap,
  input logic             fresh,
  input logic             pps_rise,
  input logic             rd_active,
  input logic             rd_data,
  input logic             pps_local
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    cnt == LAST |=> cnt == '0);
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    cnt != LAST |=> cnt == $past(cnt) + CNT_W'(1));
  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r2_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(pps_local) |-> cnt == HALF);
  a_r2_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(pps_local) |-> cnt == '0);
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> cap == $past(cnt));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !pps_rise |=> $stable(cap));
  a_r7_flag: assert property (@(posedge clk) disable iff (rst)
    pps_rise |=> fresh);
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_active |-> !rd_data);
endmodule

bind pps_phase_capture pps_phase_capture_chk #(.CNT_W(CNT_W), .MODULUS(MODULUS)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .cap(cap), .fresh(fresh),
  .pps_rise(pps_rise), .rd_active(rd_active), .rd_data(rd_data),
  .pps_local(pps_local)
);

// File: tb/sim_pps_phase_capture.sv
`timescale 1ns/1ps
module sim_pps_phase_capture;
  localparam int W = 6;
  localparam int M = 40;
  localparam int F = W + 1;

  logic clk = 0, rst = 1, pps_ref = 0, rd_sel_n = 1, rd_clk = 0;
  logic pps_local, rd_data;
  int total = 0, bad = 0, edges = 0;
  bit done = 0;

  pps_phase_capture #(.CNT_W(W), .MODULUS(M)) u0 (
    .clk(clk), .rst(rst), .pps_ref(pps_ref), .pps_local(pps_local),
    .rd_sel_n(rd_sel_n), .rd_clk(rd_clk), .rd_data(rd_data));

  always #4 clk = ~clk;

  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic fire(output int exp);
    exp = ((edges % M) + 2) % M;
    pps_ref = 1;
  endtask

  task automatic rd(output logic [F-1:0] v, input bit mid_pps, output int mid_exp);
    mid_exp = -1;
    rd_sel_n = 0;
    repeat (6) @(negedge clk);
    for (int b = 0; b < F; b++) begin
      v[F-1-b] = rd_data;
      if (mid_pps && b == 3) fire(mid_exp);
      rd_clk = 1;
      repeat (4) @(negedge clk);
      rd_clk = 0;
      repeat (4) @(negedge clk);
    end
    rd_sel_n = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [F-1:0] v;
    int e, e2, dummy;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9 pps_local after reset", pps_local, 0);
    chk("R8 idle rd_data", rd_data, 0);
    rd(v, 0, dummy);
    chk("R9 frame after reset", v, 0);

    // R2 and R8 over two full periods
    for (int i = 0; i < 2 * M; i++) begin
      chk("R2 pps_local", pps_local, ((edges % M) >= (1 << (W - 1))) ? 1 : 0);
      chk("R8 idle rd_data", rd_data, 0);
      @(negedge clk);
    end

    // R1 R3 R5 R7: capture at every phase
    for (int ph = 0; ph < M; ph++) begin
      while ((edges % M) != ph) @(negedge clk);
      fire(e);
      repeat (4) @(negedge clk);
      pps_ref = 0;
      repeat (3) @(negedge clk);
      rd(v, 0, dummy);
      chk("R3 R1 R5 phase capture", v, (1 << W) | e);
      if (ph % 8 == 0) begin
        rd(v, 0, dummy);
        chk("R7 reread clears status", v, e);
      end
    end

    // R4 held-high reference
    fire(e);
    repeat (5) @(negedge clk);
    rd(v, 0, dummy);
    chk("R4 first read held", v, (1 << W) | e);
    repeat (50) @(negedge clk);
    rd(v, 0, dummy);
    chk("R4 no recapture while high", v, e);
    pps_ref = 0;
    repeat (5) @(negedge clk);

    // R6 capture during a read
    fire(e);
    repeat (4) @(negedge clk);
    pps_ref = 0;
    repeat (3) @(negedge clk);
    rd(v, 1, e2);
    chk("R6 frame stable during capture", v, (1 << W) | e);
    pps_ref = 0;
    rd(v, 0, dummy);
    chk("R6 new value next read", v, (1 << W) | e2);

    // R9 reset after capture
    fire(e);
    repeat (4) @(negedge clk);
    pps_ref = 0;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 pps_local cleared", pps_local, 0);
    rd(v, 0, dummy);
    chk("R9 frame cleared", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule